// File: doc/BRIEF.md
# Serial EEPROM Bus Recovery Sequencer

This block is a master-side sequencer that brings a two-wire serial EEPROM back to a known idle state, no matter where an earlier transfer was cut off. It runs by itself once after system reset is released, and again each time a start pulse arrives while it is idle. It only ever pulls the clock or data line low or lets it go. The pull-up resistors supply every high level, so the master never fights a slave that is driving the data line low.

A run first leaves both lines released for one bit period so the bus is seen as free. It then issues a START, nine clock pulses with the data line released, a second START, and a closing STOP. The nine released bits end any byte the slave was sending with a NACK. The second START keeps a STOP that follows an interrupted write command from launching a write cycle. Every step lasts one SCL half-period of `HALF_CYC` system clocks. `busy` covers the whole run and `done` marks its end. At three points the block reads both lines back through a synchronizer and raises a sticky error flag if either line is low. The sequence still runs to the end when that happens.

Top module: `busrec_seq`

## Requirements
- R1: The block never drives a line high. `scl_oe`/`sda_oe` = 1 pulls the line low and 0 releases it, and every pattern is given as the pair {scl_oe, sda_oe}.
- R2: While `rst_n` is low, `scl_oe`, `sda_oe`, `busy`, `done` and `err` are all 0.
- R3: On the first clock edge with `rst_n` high, a run starts without any request and `busy` becomes 1.
- R4: A run opens with two half-periods of {0,0}, so both lines are released for a full bit period.
- R5: The first START is one half-period of {0,1} (data low while the clock is released), followed by one half-period of {1,1}.
- R6: Nine clock pulses follow. Data stays released: {1,0} for one half-period, then nine repeats of {0,0} and {1,0}, each one half-period long.
- R7: The run closes with one half-period each of {0,0}, {0,1} (second START), {1,1}, {0,1} (STOP setup), and {0,0} (STOP: data rises while the clock is released).
- R8: `busy` stays high for exactly 28·`HALF_CYC` cycles. On the edge where it falls, `done` is 1 for exactly one cycle.
- R9: `start_i` starts a run on the next edge when the block is idle. While `busy` is high it has no effect, and the run's pattern and length are unchanged.
- R10: At the end of the half-period before each START, and at the end of the STOP half-period, both lines are read after the synchronizer. If either reads low, `err` is set. It stays set until the next run starts, where it clears on the launch edge. The line pattern is unaffected.
- R11: `scl_oe` and `sda_oe` never change on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a recovery run (honoured only when idle) |
| scl_i | input | 1 | Sampled level of the clock line |
| sda_i | input | 1 | Sampled level of the data line |
| scl_oe | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| busy | output | 1 | High for the whole recovery run |
| done | output | 1 | One-cycle strobe when the run ends |
| err | output | 1 | Sticky flag: a line read low at a check point |

## Verification
The bench targets several off-by-one traps. A design that miscounts the released clock pulses would show eight or ten high phases in place of nine. One that skips the second START would go straight from the pulses to STOP. One that releases data in the same edge as the clock would create a spurious START or STOP. Error detection is tested with a slave that holds data low for the whole run, and again with a slave that pulls it low only during the STOP. A design that checks only before the STARTs would miss the second case. A design that aborts on error, or that forgets to clear the flag on the next run, would show a shortened pattern or a stale flag. A start pulse in the middle of a run must neither restart nor stretch the run.

// File: rtl/busrec_pkg.sv
// Package: step numbering and line patterns of the recovery run.
// Assumes one step equals one SCL half-period; the run has 28 steps.
package busrec_pkg;

    localparam int unsigned N_STEPS = 28;
    localparam int unsigned STEP_W  = $clog2(N_STEPS);

    localparam logic [STEP_W-1:0] STEP_PRE_START1 = STEP_W'(1);
    localparam logic [STEP_W-1:0] STEP_PRE_START2 = STEP_W'(23);
    localparam logic [STEP_W-1:0] STEP_STOP       = STEP_W'(27);
    localparam logic [STEP_W-1:0] STEP_LAST       = STEP_W'(N_STEPS - 1);

    // Released (1) or pulled low (0) for each line during one step.
    typedef struct packed {
        logic scl_rel;
        logic sda_rel;
    } lines_t;

    // Pattern of one step: bus free, START, nine released bits, START, STOP.
    function automatic lines_t step_lines(input logic [STEP_W-1:0] s);
        lines_t l;
        l = '{scl_rel: 1'b1, sda_rel: 1'b1};
        if (s <= STEP_W'(1)) begin
            l = '{scl_rel: 1'b1, sda_rel: 1'b1};
        end else if (s == STEP_W'(2)) begin
            l = '{scl_rel: 1'b1, sda_rel: 1'b0};
        end else if (s == STEP_W'(3)) begin
            l = '{scl_rel: 1'b0, sda_rel: 1'b0};
        end else if (s <= STEP_W'(22)) begin
            l = '{scl_rel: s[0], sda_rel: 1'b1};
        end else begin
            case (s)
                STEP_W'(23): l = '{scl_rel: 1'b1, sda_rel: 1'b1};
                STEP_W'(24): l = '{scl_rel: 1'b1, sda_rel: 1'b0};
                STEP_W'(25): l = '{scl_rel: 1'b0, sda_rel: 1'b0};
                STEP_W'(26): l = '{scl_rel: 1'b1, sda_rel: 1'b0};
                default:     l = '{scl_rel: 1'b1, sda_rel: 1'b1};
            endcase
        end
        return l;
    endfunction

    // Steps whose last cycle reads the bus back.
    function automatic logic is_probe_step(input logic [STEP_W-1:0] s);
        return (s == STEP_PRE_START1) || (s == STEP_PRE_START2) || (s == STEP_STOP);
    endfunction

endpackage

// File: rtl/busrec_tick.sv
// Half-period timer: pulses tick on the last cycle of every HALF_CYC-cycle step.
// Assumes clear restarts the count; counting only while en is high.
module busrec_tick #(
    parameter int unsigned HALF_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic en,
    output logic tick
);
    localparam int unsigned CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    generate
        if (HALF_CYC == 1) begin : g_every
            assign tick = en;
        end else begin : g_count
            localparam logic [CNT_W-1:0] TOP = CNT_W'(HALF_CYC - 1);
            logic [CNT_W-1:0] cnt;

            // Count cycles within the current half-period.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    cnt <= '0;
                end else if (en) begin
                    cnt <= (cnt == TOP) ? '0 : cnt + CNT_W'(1);
                end
            end

            assign tick = en && (cnt == TOP);
        end
    endgenerate
endmodule

// File: rtl/busrec_ctrl.sv
// Run controller: launches a run after reset or on request, walks the 28 steps,
// and registers the open-drain enables from the next step.
// Assumes tick marks the last cycle of a step.
module busrec_ctrl
    import busrec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              tick,
    output logic              launch,
    output logic              running,
    output logic [STEP_W-1:0] step,
    output logic              done,
    output logic              scl_oe,
    output logic              sda_oe
);
    logic              arm;
    logic              run_n;
    logic              done_n;
    logic [STEP_W-1:0] step_n;
    lines_t            lines_n;

    assign launch = !running && (arm || start_i);

    // Next run flag, step and end strobe.
    always_comb begin
        run_n  = running;
        step_n = step;
        done_n = 1'b0;
        if (launch) begin
            run_n  = 1'b1;
            step_n = '0;
        end else if (running && tick) begin
            if (step == STEP_LAST) begin
                run_n  = 1'b0;
                step_n = '0;
                done_n = 1'b1;
            end else begin
                step_n = step + STEP_W'(1);
            end
        end
        lines_n = step_lines(step_n);
    end

    // State and registered line enables; both lines released in reset and idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm     <= 1'b1;
            running <= 1'b0;
            step    <= '0;
            done    <= 1'b0;
            scl_oe  <= 1'b0;
            sda_oe  <= 1'b0;
        end else begin
            if (launch) arm <= 1'b0;
            running <= run_n;
            step    <= step_n;
            done    <= done_n;
            scl_oe  <= run_n && !lines_n.scl_rel;
            sda_oe  <= run_n && !lines_n.sda_rel;
        end
    end
endmodule

// File: rtl/busrec_probe.sv
// Bus read-back: synchronizes both lines and sets a sticky error when either
// reads low at the end of a check step. Assumes HALF_CYC > SYNC_STAGES.
module busrec_probe
    import busrec_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              running,
    input  logic              tick,
    input  logic [STEP_W-1:0] step,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              err
);
    logic [SYNC_STAGES-1:0] scl_q;
    logic [SYNC_STAGES-1:0] sda_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // First synchronizer stage, idle value released.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_q[0] <= 1'b1;
                        sda_q[0] <= 1'b1;
                    end else begin
                        scl_q[0] <= scl_i;
                        sda_q[0] <= sda_i;
                    end
                end
            end else begin : g_next
                // Later synchronizer stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_q[g] <= 1'b1;
                        sda_q[g] <= 1'b1;
                    end else begin
                        scl_q[g] <= scl_q[g-1];
                        sda_q[g] <= sda_q[g-1];
                    end
                end
            end
        end
    endgenerate

    logic line_low;
    assign line_low = !scl_q[SYNC_STAGES-1] || !sda_q[SYNC_STAGES-1];

    // Sticky error, cleared when a run launches.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            err <= 1'b0;
        end else if (running && tick && is_probe_step(step) && line_low) begin
            err <= 1'b1;
        end
    end
endmodule

// File: rtl/busrec_seq.sv
// Top: bus recovery sequencer for a two-wire serial EEPROM.
// Outputs are open-drain enables only; the lines' high level comes from pull-ups.
module busrec_seq #(
    parameter int unsigned HALF_CYC    = 1000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_oe,
    output logic sda_oe,
    output logic busy,
    output logic done,
    output logic err
);
    import busrec_pkg::*;

    logic              launch;
    logic              running;
    logic              tick;
    logic [STEP_W-1:0] step;

    busrec_tick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (launch),
        .en    (running),
        .tick  (tick)
    );

    busrec_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .tick    (tick),
        .launch  (launch),
        .running (running),
        .step    (step),
        .done    (done),
        .scl_oe  (scl_oe),
        .sda_oe  (sda_oe)
    );

    busrec_probe #(.SYNC_STAGES(SYNC_STAGES)) u_probe (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (launch),
        .running (running),
        .tick    (tick),
        .step    (step),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .err     (err)
    );

    assign busy = running;
endmodule

// File: rtl/busrec_chk.sv
// Checker: temporal properties of the sequencer's ports, bound to busrec_seq.
module busrec_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic scl_oe,
    input logic sda_oe,
    input logic busy,
    input logic done,
    input logic err
);
    // R2: while idle, neither line is pulled.
    a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    // R8: done lasts one cycle.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: busy only falls with done.
    a_r8_busy_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9: a start during a run neither restarts nor aborts it.
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i) |=> (busy || done));

    // R10: error only appears because of a run.
    a_r10_err_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(busy));

    // R10: error stays set while idle without a new request.
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !busy && !start_i) |=> err);

    // R11: clock and data enables never toggle together.
    a_r11_no_joint_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !(($rose(scl_oe) || $fell(scl_oe)) && ($rose(sda_oe) || $fell(sda_oe))));
endmodule

bind busrec_seq busrec_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .scl_oe  (scl_oe),
    .sda_oe  (sda_oe),
    .busy    (busy),
    .done    (done),
    .err     (err)
);

// File: tb/sim_busrec_seq.sv
// Scoreboard bench: a driver task queues the expected line segments of each run,
// a monitor measures the enable pattern segments and compares them.
module sim_busrec_seq;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic slave_low = 1'b0;
    logic scl_oe, sda_oe, busy, done, err;
    logic scl_i, sda_i;

    always #2.5 clk = ~clk;

    // Open-drain bus model with pull-ups.
    assign scl_i = !scl_oe;
    assign sda_i = !sda_oe && !slave_low;

    busrec_seq #(.HALF_CYC(H), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .scl_i(scl_i), .sda_i(sda_i),
        .scl_oe(scl_oe), .sda_oe(sda_oe),
        .busy(busy), .done(done), .err(err)
    );

    typedef struct { logic [1:0] pat; int halves; } seg_t;
    seg_t exp_q[$];

    int n_chk = 0;
    int n_bad = 0;
    int runs_done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [1:0] p, input int n);
        seg_t s;
        s.pat = p;
        s.halves = n;
        exp_q.push_back(s);
    endtask

    // Driver: expected {scl_oe,sda_oe} segments of one run (R4..R7).
    task automatic expect_run();
        push(2'b00, 2);                 // R4 bus free
        push(2'b01, 1);                 // R5 START
        push(2'b11, 1);
        push(2'b10, 1);                 // R6 data released, clock low
        for (int k = 0; k < 9; k++) begin
            push(2'b00, 1);
            push(2'b10, 1);
        end
        push(2'b00, 1);                 // R7 setup
        push(2'b01, 1);                 // second START
        push(2'b11, 1);
        push(2'b01, 1);                 // STOP setup
        push(2'b00, 1);                 // STOP
    endtask

    task automatic compare_seg(input logic [1:0] p, input int len);
        seg_t s;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R1", "unexpected segment", int'(p), -1);
        end else begin
            s = exp_q.pop_front();
            chk(p == s.pat, "R6", "segment pattern", int'(p), int'(s.pat));
            chk(len == s.halves * H, "R7", "segment length", len, s.halves * H);
        end
    endtask

    // Monitor: samples at negedge, measures segments and busy length.
    logic [1:0] prev;
    int seg_len;
    int busy_len;
    bit in_run = 0;
    always @(negedge clk) begin
        logic [1:0] cur;
        cur = {scl_oe, sda_oe};
        if (!rst_n) begin
            in_run = 0;
        end else if (!in_run) begin
            if (done) chk(1'b0, "R8", "done outside run", 1, 0);
            if (busy) begin
                in_run = 1;
                seg_len = 1;
                busy_len = 1;
                prev = cur;
            end
        end else if (done) begin
            compare_seg(prev, seg_len);
            chk(busy_len == 28 * H, "R8", "busy length", busy_len, 28 * H);
            chk(!busy, "R8", "busy low with done", int'(busy), 0);
            chk(exp_q.size() == 0, "R6", "segments left", exp_q.size(), 0);
            in_run = 0;
            runs_done++;
        end else begin
            if (!busy) chk(1'b0, "R8", "busy dropped early", 0, 1);
            busy_len++;
            if (cur != prev) begin
                compare_seg(prev, seg_len);
                seg_len = 1;
                prev = cur;
            end else begin
                seg_len++;
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        // R2: reset state.
        repeat (5) @(negedge clk);
        chk(!scl_oe && !sda_oe, "R2", "lines in reset", {scl_oe, sda_oe}, 0);
        chk(!busy && !done, "R2", "busy/done in reset", {busy, done}, 0);
        chk(!err, "R2", "err in reset", int'(err), 0);

        // R3: automatic run after reset.
        expect_run();
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy, "R3", "busy after reset", int'(busy), 1);
        wait (runs_done == 1);
        chk(!err, "R10", "clean run err", int'(err), 0);

        // R9: idle stays idle; start launches; mid-run start ignored.
        repeat (10) @(negedge clk);
        chk(!busy && !scl_oe && !sda_oe, "R2", "idle released", {busy, scl_oe, sda_oe}, 0);
        expect_run();
        pulse_start();
        chk(busy, "R9", "busy after start", int'(busy), 1);
        repeat (10 * H) @(negedge clk);
        pulse_start();
        wait (runs_done == 2);
        repeat (5) @(negedge clk);
        chk(!busy, "R9", "no rerun from mid-run start", int'(busy), 0);

        // R10: slave holds data low for the whole run.
        slave_low = 1'b1;
        expect_run();
        pulse_start();
        wait (runs_done == 3);
        chk(err, "R10", "err with stuck data", int'(err), 1);
        slave_low = 1'b0;
        repeat (10) @(negedge clk);
        chk(err, "R10", "err sticky while idle", int'(err), 1);

        // R10: new run clears err.
        expect_run();
        pulse_start();
        chk(!err, "R10", "err cleared at launch", int'(err), 0);
        wait (runs_done == 4);
        chk(!err, "R10", "clean rerun err", int'(err), 0);

        // R10: slave pulls data low only during STOP.
        repeat (4) @(negedge clk);
        expect_run();
        pulse_start();
        repeat (26 * H + 2) @(negedge clk);
        slave_low = 1'b1;
        wait (runs_done == 5);
        chk(err, "R10", "err at STOP check", int'(err), 1);
        slave_low = 1'b0;

        repeat (5) @(negedge clk);
        summary();
        $finish;
    end
endmodule